// File: doc/BRIEF.md
# Read-After-Write Register File

This block is the general-purpose register file of a pipelined processor datapath. It holds 32 words of 32 bits. Two read ports, A and B, return operands combinationally. One write port with an enable stores a result on the rising clock edge. Each port takes a 5-bit register index.

A write-back stage and a dependent operand read can share one cycle. When the write port targets the register that a read port is selecting, the incoming write data goes straight through to that read output in the same cycle. The stored copy is not used for that read. This gives, in a single-clock design, the effect of writing in the first half of a cycle and reading in the second half.

Register index 0 is a constant zero. Writes to it are discarded and it is never forwarded. A synchronous reset clears every entry.

Top module: `rf_raw_top`

## Requirements
- R1: Once a synchronous reset has been applied and released, every register reads 0 on both ports until it is written.
- R2: When `wr_en_i` is 1 and `wr_addr_i` is not 0, `wr_data_i` is stored on the rising clock edge. Later reads of that index return it on either port.
- R3: When `wr_en_i` is 1, `wr_addr_i` equals `rd_a_addr_i` and that index is not 0, `rd_a_data_o` equals `wr_data_i` in the same cycle. This holds even if the register previously held another value.
- R4: Forwarding is decided separately for each port. Port B forwards under the same rule using `rd_b_addr_i`. A port that selects a different register returns the stored value of that register, and this is not affected by the other port.
- R5: When `wr_en_i` is 0, nothing is stored and nothing is forwarded. Both ports return the stored contents, whatever is on `wr_addr_i` and `wr_data_i`.
- R6: Index 0 always reads 0 on both ports, including in a cycle that writes index 0 with the enable set, and in all later cycles.
- R7: A write changes only the register it addresses. All other indices keep their values.
- R8: If reset and a write are both asserted at the same clock edge, reset wins. The written register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; storage updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high, clears all entries |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Index of the register to write |
| wr_data_i | input | 32 | Data to write |
| rd_a_addr_i | input | 5 | Index read by port A |
| rd_a_data_o | output | 32 | Port A read data (combinational) |
| rd_b_addr_i | input | 5 | Index read by port B |
| rd_b_data_o | output | 32 | Port B read data (combinational) |

## Verification
A faulty stored entry stays hidden until a port selects that index. The first such read, in the cycle after the bad edge or any time later, returns the wrong word. For this reason the bench fills every index with a distinct value and reads each one back on both ports. A faulty forwarding decision shows up in the same cycle as the write: the read port returns the old stored word instead of the incoming one, or returns a forwarded word when the enable is low. A leak into index 0 shows up as a nonzero read of index 0 in the write cycle or at any later time.

// File: rtl/rf_raw_pkg.sv
package rf_raw_pkg;

    // Default geometry of the register file.
    localparam int unsigned RF_NUM_REGS_DEF = 32;
    localparam int unsigned RF_DATA_W_DEF   = 32;

    // Number of combinational read ports built by the top level.
    localparam int unsigned RF_RD_PORTS     = 2;

    // Kind of source chosen by a read port, for readability of the mux.
    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_STORE  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned ADDR_W   = 5
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [NUM_REGS-1:0] we_vec
);

    // One-hot enable per entry; entry 0 is never enabled.
    always_comb begin
        we_vec = '0;
        for (int i = 1; i < NUM_REGS; i++) begin
            we_vec[i] = wr_en && (wr_addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              we_vec,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d;
    store_t st_q;

    // Next-state: reset clears everything and beats any write.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (we_vec[i]) begin
                    st_d.regs[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.regs;

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_raw_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 5
) (
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [DATA_W-1:0]                rd_data
);

    rd_src_e src;

    // Choose the source: constant zero, same-cycle write, or stored entry.
    always_comb begin
        if (rd_addr == '0) begin
            src = SRC_ZERO;
        end else if (wr_en && (wr_addr == rd_addr)) begin
            src = SRC_BYPASS;
        end else begin
            src = SRC_STORE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ZERO:   rd_data = '0;
            SRC_BYPASS: rd_data = wr_data;
            SRC_STORE:  rd_data = regs[rd_addr];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rf_raw_top.sv
module rf_raw_top
    import rf_raw_pkg::*;
#(
    parameter int unsigned NUM_REGS = RF_NUM_REGS_DEF,
    parameter int unsigned DATA_W   = RF_DATA_W_DEF,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [ADDR_W-1:0] rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o
);

    logic [NUM_REGS-1:0]                 we_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0]     regs;
    logic [RF_RD_PORTS-1:0][ADDR_W-1:0]  rd_addr_all;
    logic [RF_RD_PORTS-1:0][DATA_W-1:0]  rd_data_all;

    assign rd_addr_all[0] = rd_a_addr_i;
    assign rd_addr_all[1] = rd_b_addr_i;
    assign rd_a_data_o    = rd_data_all[0];
    assign rd_b_data_o    = rd_data_all[1];

    rf_wr_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .we_vec  (we_vec)
    );

    rf_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk_i),
        .rst     (rst_i),
        .we_vec  (we_vec),
        .wr_data (wr_data_i),
        .regs    (regs)
    );

    for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
        rf_read_port #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .ADDR_W   (ADDR_W)
        ) u_port (
            .rd_addr (rd_addr_all[p]),
            .regs    (regs),
            .wr_en   (wr_en_i),
            .wr_addr (wr_addr_i),
            .wr_data (wr_data_i),
            .rd_data (rd_data_all[p])
        );
    end

endmodule

// File: rtl/rf_raw_checker.sv
module rf_raw_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data
);

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0)); // R6
    AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0)); // R6
    AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_addr == rd_a_addr) |-> (rd_a_data == wr_data)); // R3
    AST_FWD_PORT_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_addr == rd_b_addr) |-> (rd_b_data == wr_data)); // R4
    AST_STORED_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_addr) != '0 && rd_a_addr == $past(wr_addr)
         && !(wr_en && wr_addr == rd_a_addr)) |-> (rd_a_data == $past(wr_data))); // R2
    AST_CLEARED_A: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !(wr_en && wr_addr == rd_a_addr)) |-> (rd_a_data == '0)); // R1

endmodule

bind rf_raw_top rf_raw_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .rd_a_addr (rd_a_addr_i),
    .rd_a_data (rd_a_data_o),
    .rd_b_addr (rd_b_addr_i),
    .rd_b_data (rd_b_data_o)
);

// File: tb/test_rf_raw_top.sv
`timescale 1ns/1ps
module test_rf_raw_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd_a_addr;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_addr;
    logic [31:0] rd_b_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rf_raw_top i_rf_raw_top (
        .clk_i       (clk),
        .rst_i       (rst),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_a_addr_i (rd_a_addr),
        .rd_a_data_o (rd_a_data),
        .rd_b_addr_i (rd_b_addr),
        .rd_b_data_o (rd_b_data)
    );

    // we, waddr, wdata, raddr A, raddr B, expect A, expect B, tag
    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [15:0] tag;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd0,  32'hA5A5_0001, 32'h0,         "R3"},
        '{1'b0, 5'd0,  32'h0,         5'd5,  5'd5,  32'hA5A5_0001, 32'hA5A5_0001, "R2"},
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0,  32'h0,         32'h0,         "R6"},
        '{1'b0, 5'd0,  32'h0,         5'd0,  5'd0,  32'h0,         32'h0,         "R6"},
        '{1'b1, 5'd31, 32'hDEAD_BEEF, 5'd5,  5'd31, 32'hA5A5_0001, 32'hDEAD_BEEF, "R4"},
        '{1'b1, 5'd5,  32'h1234_5678, 5'd5,  5'd31, 32'h1234_5678, 32'hDEAD_BEEF, "R3"},
        '{1'b0, 5'd5,  32'hFFFF_FFFF, 5'd5,  5'd31, 32'h1234_5678, 32'hDEAD_BEEF, "R5"},
        '{1'b0, 5'd1,  32'hCAFE_0000, 5'd5,  5'd1,  32'h1234_5678, 32'h0,         "R7"},
        '{1'b1, 5'd1,  32'h0000_0001, 5'd31, 5'd1,  32'hDEAD_BEEF, 32'h0000_0001, "R4"},
        '{1'b0, 5'd0,  32'h0,         5'd1,  5'd5,  32'h0000_0001, 32'h1234_5678, "R2"}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 | (32'(i) * 32'h0001_0101);
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every index on both ports
        for (int i = 0; i < 32; i++) begin
            rd_a_addr = 5'(i);
            rd_b_addr = 5'(31 - i);
            #1;
            check("R1", "reset A", rd_a_data, 32'h0);
            check("R1", "reset B", rd_b_data, 32'h0);
        end

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en = VECS[v].we; wr_addr = VECS[v].wa; wr_data = VECS[v].wd;
            rd_a_addr = VECS[v].ra; rd_b_addr = VECS[v].rb;
            #1;
            check(string'(VECS[v].tag), "vector A", rd_a_data, VECS[v].ea);
            check(string'(VECS[v].tag), "vector B", rd_b_data, VECS[v].eb);
        end

        // R8: reset and write at the same edge, reset wins
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h7777_7777;
        rd_a_addr = 5'd9; rd_b_addr = 5'd9;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        rd_a_addr = 5'd7; rd_b_addr = 5'd5;
        #1;
        check("R8", "write under reset", rd_a_data, 32'h0);
        check("R1", "cleared after reset", rd_b_data, 32'h0);

        // R7: fill every index with a distinct word, then read all back
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = pat(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 32; i++) begin
            rd_a_addr = 5'(i);
            rd_b_addr = 5'(31 - i);
            #1;
            check("R7", "fill A", rd_a_data, (i == 0) ? 32'h0 : pat(i));
            check("R7", "fill B", rd_b_data, (i == 31) ? 32'h0 : pat(31 - i));
        end

        // R5: enable low with matching address forwards nothing, stores nothing
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd12; wr_data = 32'h0BAD_0BAD;
        rd_a_addr = 5'd12; rd_b_addr = 5'd12;
        #1;
        check("R5", "no forward", rd_a_data, pat(12));
        @(negedge clk);
        wr_addr = 5'd0;
        #1;
        check("R5", "no store", rd_b_data, pat(12));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule